// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is a slave-only I2C target that lets an external host reach a bank of 256 byte-wide control registers through an 8-bit internal pointer. A fast system clock oversamples both bus lines. Each line passes through a two-stage synchronizer and a three-sample agreement filter, and only then are clock edges, START and STOP detected. The block pulls SDA low through an open-drain enable output and never drives it high.

After the 7-bit device address, the first byte of a write transfer always loads the internal pointer. Every later byte is written at the pointer, and the pointer then advances. A read transfer returns bytes starting at the pointer and advances it after each byte, so current-address reads, random reads built with a repeated START, and multi-byte bursts in both directions all come from the same pointer. The pointer wraps from 0xFF to 0x00. One strap input chooses between two device addresses.

Written bytes leave on a valid/ready port. The block raises `wr_valid` together with `wr_addr` and `wr_data` and holds all three unchanged until a cycle with `wr_ready` high. If another data byte finishes while that write is still waiting, the new byte is not acknowledged on the bus and is discarded, and the pointer does not move. Reads use a plain combinational lookup: `rd_addr` always shows the pointer, and `rd_data` is sampled on the SCL falling edge that starts each byte sent to the host.

Top module: `i2c_regbank_slave`

## Requirements
- R1: The block acknowledges a device-address byte only when its upper seven bits equal 0x1C (with `addr_sel` = 0) or 0x1D (with `addr_sel` = 1), which are 0x38 and 0x3A in 8-bit write form. Bit 0 of that byte is the direction: 1 = read, 0 = write. For any other address the block stays silent and performs no write until the next START.
- R2: A START (SDA falling while SCL is high) restarts address reception from any state, including in the middle of a transfer. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R3: In a write transfer, the first byte after the address sets the pointer. Each later byte is acknowledged, written at the pointer, and followed by a pointer increment that wraps from 0xFF to 0x00.
- R4: A read transfer that is not preceded by a pointer write returns bytes starting at the pointer value left by the previous access.
- R5: A write of the pointer, then a repeated START, then the address with the read bit returns bytes starting at the newly written pointer.
- R6: Read bytes are sent MSB first. The block keeps sending consecutive bytes while the host acknowledges. After a host not-acknowledge it releases SDA and stops sending until the next START, and the pointer then holds the address after the last byte sent.
- R7: `sda_oe` changes only while the filtered SCL is low.
- R8: While a write waits on `wr_ready`, `wr_valid`, `wr_addr` and `wr_data` stay unchanged. A data byte that finishes during that wait is not acknowledged, is not written, and leaves the pointer where it was.
- R9: A pulse on SCL or SDA lasting fewer than three system clocks after synchronization does not count as an edge, a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Strap that selects device address 0x1C or 0x1D |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received |
| sda_oe | output | 1 | High pulls SDA low |
| wr_valid | output | 1 | A register write is offered |
| wr_ready | input | 1 | Internal logic accepts the offered write |
| wr_addr | output | 8 | Register address of the offered write |
| wr_data | output | 8 | Data of the offered write |
| rd_addr | output | 8 | Current pointer, used as the read lookup address |
| rd_data | input | 8 | Register contents at `rd_addr` |

## Verification
Two events can fall in the same cycle: a data byte completing on the bus and an earlier register write still waiting at the write port. The bench provokes this by holding `wr_ready` low across two consecutive data bytes. It then judges the acknowledge bit of the second byte, confirms that the first write stays held unchanged, and after releasing `wr_ready` confirms that only the first byte reached the register bank. A second overlap, a filtered-out SDA pulse during SCL high in the middle of a data byte, is judged by comparing the written byte with the value the host sent.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)
        dout <= 1'b1;
      else if (~|hist_q)
        dout <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_d;
  assign scl_fall  = ~scl & scl_d;
  assign start_det = scl & scl_d & sda_d & ~sda;
  assign stop_det  = scl & scl_d & ~sda_d & sda;
endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_rb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    dev_addr,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          sda_oe,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data
);
  localparam int CNT_W = $clog2(DW + 1) + 1;
  localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(DW);
  localparam logic [CNT_W-1:0] LAST_TX   = CNT_W'(DW - 1);

  tgt_state_t       state;
  logic [CNT_W-1:0] bit_cnt;
  logic [DW-1:0]    shreg;
  logic [DW-1:0]    tx_q;
  logic [AW-1:0]    ptr;
  logic             rw_q;
  logic             host_ack;
  logic             wr_pending;

  assign rd_addr    = ptr;
  assign wr_pending = wr_valid & ~wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx_q     <= '0;
      ptr      <= '0;
      rw_q     <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      if (wr_valid && wr_ready)
        wr_valid <= 1'b0;

      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise) begin
              shreg   <= {shreg[DW-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == BYTE_DONE) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[DW-1:1] == dev_addr) begin
                  sda_oe <= 1'b1;
                  rw_q   <= shreg[0];
                  state  <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_SUB) begin
                ptr    <= AW'(shreg);
                sda_oe <= 1'b1;
                state  <= ST_SUB_ACK;
              end else begin
                if (!wr_pending) begin
                  wr_valid <= 1'b1;
                  wr_addr  <= ptr;
                  wr_data  <= shreg;
                  ptr      <= ptr + 1'b1;
                  sda_oe   <= 1'b1;
                end
                state <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw_q) begin
                tx_q   <= {rd_data[DW-2:0], 1'b0};
                sda_oe <= ~rd_data[DW-1];
                ptr    <= ptr + 1'b1;
                state  <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_SUB;
              end
            end
          end
          ST_SUB_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bit_cnt == LAST_TX) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                state   <= ST_RACK;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
                sda_oe  <= ~tx_q[DW-1];
                tx_q    <= {tx_q[DW-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack) begin
                tx_q   <= {rd_data[DW-2:0], 1'b0};
                sda_oe <= ~rd_data[DW-1];
                ptr    <= ptr + 1'b1;
                state  <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter int         AW          = 8,
  parameter int         DW          = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter logic [5:0] DEV_ADDR_HI = 6'h0E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_sel,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw;
  logic [NLINES-1:0] line_filt;
  logic scl_filt, sda_filt;
  logic scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] dev_addr;

  assign line_raw = {sda_in, scl_in};
  assign scl_filt = line_filt[0];
  assign sda_filt = line_filt[1];
  assign dev_addr = {DEV_ADDR_HI, addr_sel};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (line_raw[g]),
      .dout (line_filt[g])
    );
  end

  i2c_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl_filt),
    .sda      (sda_filt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_target_fsm #(
    .AW(AW),
    .DW(DW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_addr (dev_addr),
    .sda_s    (sda_filt),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/i2c_regbank_chk.sv
module i2c_regbank_chk #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          scl_filt,
  input logic          stop_det
);
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R8

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_filt); // R7

  AST_WR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> sda_oe); // R3

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R2
endmodule

bind i2c_regbank_slave i2c_regbank_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sda_oe  (sda_oe),
  .wr_valid(wr_valid),
  .wr_ready(wr_ready),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .scl_filt(scl_filt),
  .stop_det(stop_det)
);

// File: tb/tb_i2c_regbank_slave.sv
`timescale 1ns/1ps
module tb_i2c_regbank_slave;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_sel = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe, wr_valid, wr_ready;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  wire  sda_bus = m_sda & ~sda_oe;

  logic [7:0] regs [256];
  logic [7:0] exp_mem [256];
  int n_cmp = 0;
  int n_fail = 0;
  int oe_viol = 0;
  bit done = 1'b0;
  bit hold_ready = 1'b0;
  logic last_oe = 1'b0;

  always #2.5 clk = ~clk;

  i2c_regbank_slave dut (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
    .scl_in(m_scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign wr_ready = ~hold_ready;
  assign rd_data  = regs[rd_addr];

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) ^ 8'h5A);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) regs[i] <= pat(i);
    end else if (wr_valid && wr_ready) begin
      regs[wr_addr] <= wr_data;
    end
  end

  // R7 monitor: the open-drain enable may only move while the bus clock is low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== last_oe && m_scl) oe_viol++;
    last_oe = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic qwait; repeat (Q) @(negedge clk); endtask
  task automatic bus_start; m_sda = 1'b0; qwait; m_scl = 1'b0; qwait; endtask
  task automatic bus_rstart;
    m_sda = 1'b1; qwait; m_scl = 1'b1; qwait; m_sda = 1'b0; qwait; m_scl = 1'b0; qwait;
  endtask
  task automatic bus_stop;
    m_sda = 1'b0; qwait; m_scl = 1'b1; qwait; m_sda = 1'b1; qwait; qwait;
  endtask

  task automatic tx_byte(input logic [7:0] b, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qwait; m_scl = 1'b1;
      if (glitch && (i == 4 || i == 3)) begin
        repeat (4) @(negedge clk); m_sda = ~b[i];
        repeat (2) @(negedge clk); m_sda = b[i];
        repeat (Q - 6) @(negedge clk);
      end else begin
        qwait;
      end
      qwait; m_scl = 1'b0; qwait;
    end
    m_sda = 1'b1; qwait; m_scl = 1'b1; qwait;
    acked = (sda_bus == 1'b0);
    qwait; m_scl = 1'b0; qwait;
  endtask

  task automatic rx_byte(input bit ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qwait; m_scl = 1'b1; qwait; b = {b[6:0], sda_bus}; qwait; m_scl = 1'b0;
    end
    m_sda = ack ? 1'b0 : 1'b1; qwait; m_scl = 1'b1; qwait; qwait; m_scl = 1'b0; qwait;
    m_sda = 1'b1;
  endtask

  task automatic mem_compare(input string req);
    int bad = 0;
    int first = -1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 256; i++)
      if (regs[i] !== exp_mem[i]) begin bad++; if (first < 0) first = i; end
    chk(bad == 0, req, first, -1);
  endtask

  task automatic do_write(input logic [7:0] dev8, input logic [7:0] sub,
                          input int n, input logic [7:0] seed);
    bit a;
    bus_start;
    tx_byte(dev8, 1'b0, a); chk(a, "R1 addr ack", a, 1);
    tx_byte(sub, 1'b0, a);  chk(a, "R3 sub ack", a, 1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = seed + 8'(k * 13);
      tx_byte(d, 1'b0, a); chk(a, "R3 data ack", a, 1);
      exp_mem[8'(sub + k)] = d;
    end
    bus_stop;
    mem_compare("R3 burst write contents");
  endtask

  task automatic do_read(input bit rnd, input logic [7:0] dev8, input logic [7:0] sub,
                         input logic [7:0] from, input int n, input string req);
    bit a;
    logic [7:0] b;
    bus_start;
    if (rnd) begin
      tx_byte(dev8, 1'b0, a); tx_byte(sub, 1'b0, a);
      chk(a, req, a, 1);
      bus_rstart;
    end
    tx_byte(dev8 | 8'h01, 1'b0, a); chk(a, "R1 read addr ack", a, 1);
    for (int k = 0; k < n; k++) begin
      rx_byte(k < n - 1, b);
      chk(b === exp_mem[8'(from + k)], req, b, exp_mem[8'(from + k)]);
    end
    qwait;
    chk(sda_oe == 1'b0, "R6 released after nack", sda_oe, 0);
    bus_stop;
  endtask

  initial begin
    bit a;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0 && wr_valid == 1'b0, "R2 reset idle", {sda_oe, wr_valid}, 0);

    // R1: address sweep for both strap values
    for (int s = 0; s < 2; s++) begin
      addr_sel = s[0];
      for (int ad = 8'h10; ad < 8'h30; ad++) begin
        bus_start;
        tx_byte(8'(ad << 1), 1'b0, a);
        chk(a == (ad == 8'h1C + s), "R1 address match", a, ad == 8'h1C + s);
        bus_stop;
      end
    end
    // R1: non-matching write attempt leaves registers alone
    addr_sel = 1'b0;
    bus_start; tx_byte(8'h3A, 1'b0, a); tx_byte(8'h05, 1'b0, a); tx_byte(8'hEE, 1'b0, a);
    bus_stop;
    mem_compare("R1 no write on mismatch");

    // R3: burst write across the 0xFF wrap, strap high
    addr_sel = 1'b1;
    do_write(8'h3A, 8'hFD, 5, 8'h21);
    // R4: current-address read continues at 0x02
    do_read(1'b0, 8'h3A, 8'h00, 8'h02, 3, "R4 current read");
    // R5: random read
    do_read(1'b1, 8'h3A, 8'h80, 8'h80, 4, "R5 random read");
    // R6: pointer after nack is 0x84
    do_read(1'b0, 8'h3A, 8'h00, 8'h84, 1, "R6 pointer after nack");
    // R5 with wrap
    do_read(1'b1, 8'h3A, 8'hFF, 8'hFF, 2, "R5 random read wrap");

    // R2: repeated START abandons the first pointer write
    bus_start; tx_byte(8'h3A, 1'b0, a); tx_byte(8'h20, 1'b0, a);
    bus_rstart; tx_byte(8'h3A, 1'b0, a); tx_byte(8'h30, 1'b0, a);
    tx_byte(8'hC3, 1'b0, a); chk(a, "R2 ack after restart", a, 1);
    exp_mem[8'h30] = 8'hC3;
    bus_stop;
    mem_compare("R2 restart write");

    // R8: back-pressure, second byte must be refused
    hold_ready = 1'b1;
    bus_start; tx_byte(8'h3A, 1'b0, a); tx_byte(8'h40, 1'b0, a);
    tx_byte(8'h99, 1'b0, a); chk(a, "R8 first byte ack", a, 1);
    tx_byte(8'h66, 1'b0, a); chk(!a, "R8 second byte nack", a, 0);
    chk(wr_valid && wr_addr == 8'h40 && wr_data == 8'h99, "R8 held write",
        {wr_valid, wr_addr, wr_data}, {1'b1, 8'h40, 8'h99});
    bus_stop;
    hold_ready = 1'b0;
    exp_mem[8'h40] = 8'h99;
    mem_compare("R8 only first byte stored");
    do_read(1'b0, 8'h3A, 8'h00, 8'h41, 1, "R8 pointer unchanged by nack");

    // R9: short pulses on SDA during SCL high inside a data byte
    bus_start; tx_byte(8'h3A, 1'b0, a); tx_byte(8'h55, 1'b0, a);
    tx_byte(8'h96, 1'b1, a); chk(a, "R9 ack with glitches", a, 1);
    exp_mem[8'h55] = 8'h96;
    bus_stop;
    mem_compare("R9 glitch-free byte");

    chk(oe_viol == 0, "R7 sda_oe moved with SCL high", oe_viol, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_fail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end
endmodule